// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous SRAM. Reads and writes can follow each other on consecutive clock edges with no idle cycle between them. A write takes its address, direction and byte-lane selects on one clock edge. Its data is taken two enabled edges later. A read sampled on an enabled edge returns its word two enabled edges later.

Two write-address stages hold each pending write until its data arrives. A read that reaches the array while a write to the same word is still waiting for its data gets the new bytes forwarded into its result.

Bursts of four words are formed by a 2-bit counter. The counter steps through the low address bits in either linear or exclusive-or order. A stall input freezes the whole block for a cycle. A doze input freezes it as well, keeps the array contents and turns the data output off. The bidirectional data bus is modelled as separate `din`, `dout` and `dout_en` signals.

Top module: `nowait_sram`

## Requirements
- R1: While `rst_n` is low and on the first edge after it, `dout_en` is low and the block holds no command.
- R2: A read sampled on enabled edge k drives the word at its address on `dout`, with `dout_en` high, after enabled edge k+2. This holds only while `out_off` and `doze` are low. After an enabled edge whose command two enabled edges back was not a read, `dout_en` is low.
- R3: A write sampled on enabled edge k takes `din` on enabled edge k+2. Only lanes whose `lane_wr_n` bit was low at edge k are stored. Lane i is `din[9*i+8:9*i]`.
- R4: A write with every `lane_wr_n` bit high (write abort) changes no word of the array.
- R5: An enabled edge with `burst_next` low is a load. A load changes nothing unless the select inputs are `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other select pattern on a load makes the edge idle and ends any burst.
- R6: An enabled edge with `burst_next` high during a burst repeats the burst's direction. It uses the next count of a 2-bit counter that is 0 on the load edge. With `xor_order`=0, address bits [1:0] are base plus count, modulo 4. The upper bits stay those of the base.
- R7: With `xor_order`=1, address bits [1:0] of a burst are the base's low bits XOR the count.
- R8: An edge with `stall` high changes no state and writes nothing. `dout`, and the value behind `dout_en`, hold.
- R9: A read whose address matches a write still waiting for its data returns that write's selected lanes merged with the stored lanes.
- R10: While `doze` is high, edges are ignored, the array keeps its contents and `dout_en` is low. Doze is to be raised only while deselected.
- R11: `out_off` high forces `dout_en` low without disturbing the pending read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr | input | AW | Word address, sampled on load edges |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| wr_n | input | 1 | Low for write, high for read, on load edges |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| burst_next | input | 1 | High: continue burst; low: load new address |
| stall | input | 1 | High: ignore this edge |
| xor_order | input | 1 | Burst order: 0 linear, 1 exclusive-or |
| doze | input | 1 | Sleep: ignore edges, output off |
| out_off | input | 1 | High disables the output driver |
| din | input | LANES*LANE_W | Write data, two enabled edges after its address |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Output driver enable |

## Verification
The case that is hardest to reach from the ports is a read that lands while a write to the same word is still waiting for its data. It is harder still when stall or doze edges sit in between and stretch the pipeline. Directed sequences issue a write load followed at once by a read of the same address. They also insert stalls between a write and its data, and doze while a read result is pending. A long random run with frequent burst continuation and short address reuse then mixes these cases in both burst orders. Every result is checked against a word-level model kept in the bench.

// File: rtl/nwsram_pkg.sv
`timescale 1ns/1ps
package nwsram_pkg;
  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;

  // edges between a command and its data (write) or its output (read)
  localparam int unsigned LATE_STAGES = 2;

  // low address bits of a burst beat
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic       use_xor);
    return use_xor ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/nwsram_seq.sv
`timescale 1ns/1ps
module nwsram_seq
  import nwsram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [AW-1:0]    addr_i,
  input  logic             sel_i,
  input  logic             wr_n_i,
  input  logic [LANES-1:0] lane_n_i,
  input  logic             next_i,
  input  logic             xor_i,
  output op_e              op_o,
  output logic [AW-1:0]    addr_o,
  output logic [LANES-1:0] lane_n_o
);
  logic          act_q, act_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;

  always_comb begin
    op_o     = OP_IDLE;
    addr_o   = addr_i;
    lane_n_o = lane_n_i;
    act_d    = act_q;
    wr_d     = wr_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    if (!next_i) begin
      if (sel_i) begin
        op_o   = wr_n_i ? OP_RD : OP_WR;
        act_d  = 1'b1;
        wr_d   = !wr_n_i;
        base_d = addr_i;
        cnt_d  = 2'd0;
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q) begin
      cnt_d  = cnt_q + 2'd1;
      op_o   = wr_q ? OP_WR : OP_RD;
      addr_o = {base_q[AW-1:2], beat_low(base_q[1:0], cnt_d, xor_i)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else if (en) begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/nwsram_pipe.sv
`timescale 1ns/1ps
module nwsram_pipe
  import nwsram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int NSTG  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  op_e                       op_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [LANES-1:0]          lane_n_i,
  output op_e  [NSTG-1:0]           op_o,
  output logic [NSTG-1:0][AW-1:0]   addr_o,
  output logic [LANES-1:0]          lane_n_o
);
  logic [NSTG-1:0][LANES-1:0] lane_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTG; i++) begin
        op_o[i]   <= OP_IDLE;
        addr_o[i] <= '0;
        lane_q[i] <= '1;
      end
    end else if (en) begin
      op_o[0]   <= op_i;
      addr_o[0] <= addr_i;
      lane_q[0] <= lane_n_i;
      for (int i = 1; i < NSTG; i++) begin
        op_o[i]   <= op_o[i-1];
        addr_o[i] <= addr_o[i-1];
        lane_q[i] <= lane_q[i-1];
      end
    end
  end

  assign lane_n_o = lane_q[NSTG-1];
endmodule

// File: rtl/nwsram_array.sv
`timescale 1ns/1ps
module nwsram_array
  import nwsram_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    en,
  input  op_e                     rd_op,
  input  logic [AW-1:0]           rd_addr,
  input  op_e                     wr_op,
  input  logic [AW-1:0]           wr_addr,
  input  logic [LANES-1:0]        wr_lane_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic hit;
  assign hit = (wr_op == OP_WR) && (wr_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;
    logic              lane_wr;

    assign lane_wr = en && (wr_op == OP_WR) && !wr_lane_n[g];

    always_ff @(posedge clk) begin
      if (lane_wr)
        mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
      if (en && rd_op == OP_RD)
        rd_q <= (hit && !wr_lane_n[g]) ? wdata[g*LANE_W +: LANE_W] : mem[rd_addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/nowait_sram.sv
`timescale 1ns/1ps
module nowait_sram
  import nwsram_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    burst_next,
  input  logic                    stall,
  input  logic                    xor_order,
  input  logic                    doze,
  input  logic                    out_off,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DW   = LANES * LANE_W;
  localparam int NSTG = LATE_STAGES;

  logic en, sel;
  assign en  = !stall && !doze;
  assign sel = !sel_a_n && sel_b && !sel_c_n;

  op_e                    cur_op;
  logic [AW-1:0]          cur_addr;
  logic [LANES-1:0]       cur_lane_n;
  op_e  [NSTG-1:0]        st_op;
  logic [NSTG-1:0][AW-1:0] st_addr;
  logic [LANES-1:0]       st_lane_n;
  logic [DW-1:0]          rdata;
  logic [DW-1:0]          out_q;
  logic                   out_vld;

  nwsram_seq #(.AW(AW), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en),
    .addr_i(addr), .sel_i(sel), .wr_n_i(wr_n), .lane_n_i(lane_wr_n),
    .next_i(burst_next), .xor_i(xor_order),
    .op_o(cur_op), .addr_o(cur_addr), .lane_n_o(cur_lane_n)
  );

  nwsram_pipe #(.AW(AW), .LANES(LANES), .NSTG(NSTG)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(en),
    .op_i(cur_op), .addr_i(cur_addr), .lane_n_i(cur_lane_n),
    .op_o(st_op), .addr_o(st_addr), .lane_n_o(st_lane_n)
  );

  nwsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .en(en),
    .rd_op(st_op[0]), .rd_addr(st_addr[0]),
    .wr_op(st_op[NSTG-1]), .wr_addr(st_addr[NSTG-1]), .wr_lane_n(st_lane_n),
    .wdata(din), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_q   <= '0;
    end else if (en) begin
      out_vld <= (st_op[NSTG-1] == OP_RD);
      if (st_op[NSTG-1] == OP_RD)
        out_q <= rdata;
    end
  end

  assign dout_en = out_vld && !out_off && !doze;
  assign dout    = dout_en ? out_q : '0;
endmodule

// File: rtl/nwsram_chk.sv
`timescale 1ns/1ps
module nwsram_chk #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          doze,
  input logic          out_off,
  input logic          burst_next,
  input logic          xor_order,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          dout_en,
  input logic          out_vld,
  input logic [DW-1:0] out_q,
  input logic [1:0]    s1_op,
  input logic [AW-1:0] s1_addr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_vld && s1_op == 2'd0));

  // R5
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !doze && !burst_next && !(!sel_a_n && sel_b && !sel_c_n))
      |=> s1_op == 2'd0);

  // R6
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !doze && burst_next && !xor_order && s1_op != 2'd0)
      |=> (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1) &&
          (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || doze) |=> ($stable(out_vld) && $stable(out_q) && $stable(s1_op)));

  // R10
  doze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doze |-> !dout_en);

  // R11
  out_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_off |-> !dout_en);
endmodule

bind nowait_sram nwsram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .doze(doze), .out_off(out_off),
  .burst_next(burst_next), .xor_order(xor_order),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
  .dout_en(dout_en), .out_vld(out_vld), .out_q(out_q),
  .s1_op(st_op[0]), .s1_addr(st_addr[0])
);

// File: tb/sim_nowait_sram.sv
`timescale 1ns/1ps
module sim_nowait_sram;
  localparam int AW = 8, LANES = 4, LW = 9, DW = LANES * LW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic sel_a_n, sel_b, sel_c_n, wr_n, burst_next, stall, xor_order, doze, out_off;
  logic [LANES-1:0] lane_wr_n;
  logic [DW-1:0] din, dout;
  logic dout_en;

  always #2 clk = ~clk;

  nowait_sram #(.AW(AW), .LANES(LANES), .LANE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .burst_next(burst_next),
    .stall(stall), .xor_order(xor_order), .doze(doze), .out_off(out_off),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  int nchk = 0, nerr = 0;
  string ph = "R2";

  // word-level model
  logic [DW-1:0] mm [1<<AW];
  bit m_act, m_wr;
  logic [AW-1:0] m_base;
  logic [1:0] m_cnt;
  int h_op [2];
  logic [AW-1:0] h_addr [2];
  logic [LANES-1:0] h_ln [2];
  bit exp_vld;
  logic [DW-1:0] exp_data;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge(input logic [AW-1:0] a, input bit sel, input bit wr,
                            input logic [LANES-1:0] ln, input bit nxt);
    int cop = 0;
    logic [AW-1:0] ca = a;
    logic [1:0] lo;
    if (!nxt) begin
      if (sel) begin m_act = 1; m_wr = wr; m_base = a; m_cnt = 0; cop = wr ? 2 : 1; end
      else m_act = 0;
    end else if (m_act) begin
      m_cnt = m_cnt + 2'd1;
      cop = m_wr ? 2 : 1;
      lo = xor_order ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      ca = {m_base[AW-1:2], lo};
    end
    if (h_op[1] == 2)
      for (int l = 0; l < LANES; l++)
        if (!h_ln[1][l]) mm[h_addr[1]][l*LW +: LW] = din[l*LW +: LW];
    exp_vld = (h_op[1] == 1);
    if (exp_vld) exp_data = mm[h_addr[1]];
    h_op[1] = h_op[0]; h_addr[1] = h_addr[0]; h_ln[1] = h_ln[0];
    h_op[0] = cop;     h_addr[0] = ca;        h_ln[0] = ln;
  endtask

  task automatic cyc(input logic [AW-1:0] a, input bit sel, input bit wr,
                     input logic [LANES-1:0] ln, input bit nxt, input bit stl,
                     input bit slp, input bit off);
    logic [63:0] r;
    bit e_en;
    @(negedge clk);
    addr = a;
    if (sel) {sel_a_n, sel_b, sel_c_n} = 3'b010;
    else case ($urandom % 3)
      0: {sel_a_n, sel_b, sel_c_n} = 3'b110;
      1: {sel_a_n, sel_b, sel_c_n} = 3'b000;
      default: {sel_a_n, sel_b, sel_c_n} = 3'b011;
    endcase
    wr_n = !wr; lane_wr_n = ln; burst_next = nxt; stall = stl; doze = slp; out_off = off;
    r = {$urandom(), $urandom()};
    din = r[DW-1:0];
    @(posedge clk);
    if (!stl && !slp) model_edge(a, sel, wr, ln, nxt);
    #1;
    e_en = exp_vld && !off && !slp;
    chk(dout_en == e_en, slp ? "R10" : (off ? "R11" : ph), DW'(dout_en), DW'(e_en));
    if (e_en) chk(dout == exp_data, ph, dout, exp_data);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, 0, 0, '1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; addr = '0; {sel_a_n, sel_b, sel_c_n} = 3'b110; wr_n = 1;
    lane_wr_n = '1; burst_next = 0; stall = 0; xor_order = 0; doze = 0; out_off = 0; din = '0;
    m_act = 0; exp_vld = 0; exp_data = '0;
    for (int i = 0; i < 2; i++) begin h_op[i] = 0; h_addr[i] = '0; h_ln[i] = '1; end
    repeat (3) @(posedge clk);
    #1 chk(dout_en == 1'b0, "R1", DW'(dout_en), '0);
    @(negedge clk); rst_n = 1;
    #1 chk(dout_en == 1'b0, "R1", DW'(dout_en), '0);

    // fill the whole array with linear write bursts (R3)
    ph = "R3";
    for (int b = 0; b < (1 << AW) / 4; b++) begin
      cyc(AW'(b * 4), 1, 1, '0, 0, 0, 0, 0);
      for (int k = 0; k < 3; k++) cyc('0, 0, 0, '0, 1, 0, 0, 0);
    end
    idle(3);

    // linear read burst from an unaligned base (R6)
    ph = "R6";
    cyc(8'h05, 1, 0, '1, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) cyc('0, 0, 0, '1, 1, 0, 0, 0);
    idle(3);

    // exclusive-or order read and write bursts (R7)
    ph = "R7";
    xor_order = 1;
    cyc(8'h0E, 1, 1, '0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) cyc('0, 0, 0, '0, 1, 0, 0, 0);
    cyc(8'h0E, 1, 0, '1, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) cyc('0, 0, 0, '1, 1, 0, 0, 0);
    idle(3);
    xor_order = 0;

    // write abort and partial lane write (R4, R3)
    ph = "R4";
    cyc(8'h20, 1, 1, 4'hF, 0, 0, 0, 0);
    idle(2);
    cyc(8'h20, 1, 0, '1, 0, 0, 0, 0);
    idle(3);
    ph = "R3";
    cyc(8'h21, 1, 1, 4'b1010, 0, 0, 0, 0);
    idle(2);
    cyc(8'h21, 1, 0, '1, 0, 0, 0, 0);
    idle(3);

    // read right behind a pending write to the same word (R9)
    ph = "R9";
    cyc(8'h30, 1, 1, '0, 0, 0, 0, 0);
    cyc(8'h30, 1, 0, '1, 0, 0, 0, 0);
    cyc(8'h31, 1, 1, 4'b0110, 0, 0, 0, 0);
    cyc(8'h31, 1, 0, '1, 0, 0, 0, 0);
    cyc(8'h31, 1, 0, '1, 0, 0, 0, 0);
    idle(3);

    // deselected load with write intent does nothing (R5)
    ph = "R5";
    cyc(8'h40, 0, 1, '0, 0, 0, 0, 0);
    cyc('0, 0, 0, '0, 1, 0, 0, 0);
    idle(2);
    cyc(8'h40, 1, 0, '1, 0, 0, 0, 0);
    idle(3);

    // stall between a write and its data, and during a pending read (R8)
    ph = "R8";
    cyc(8'h50, 1, 1, '0, 0, 0, 0, 0);
    cyc(8'h50, 1, 0, '1, 0, 1, 0, 0);
    cyc(8'h50, 1, 0, '1, 0, 0, 0, 0);
    cyc('0, 1, 1, '0, 0, 1, 0, 0);
    cyc('0, 0, 0, '1, 0, 1, 0, 0);
    idle(1);
    cyc('0, 1, 1, '0, 0, 1, 0, 0);
    idle(3);

    // doze while a read result is pending (R10)
    ph = "R10";
    cyc(8'h10, 1, 0, '1, 0, 0, 0, 0);
    idle(1);
    for (int k = 0; k < 4; k++) cyc(8'h10, 0, 1, '0, 0, 0, 1, 0);
    idle(3);
    cyc(8'h10, 1, 0, '1, 0, 0, 0, 0);
    idle(3);

    // output disabled during reads (R11)
    ph = "R11";
    cyc(8'h60, 1, 0, '1, 0, 0, 0, 1);
    for (int k = 0; k < 3; k++) cyc('0, 0, 0, '1, 1, 0, 0, k == 1);
    idle(3);

    // constrained random traffic in both burst orders (R2)
    ph = "R2";
    for (int m = 0; m < 2; m++) begin
      xor_order = m[0];
      for (int i = 0; i < 1500; i++)
        cyc(AW'($urandom % 24), ($urandom % 100) < 85, $urandom % 2,
            (($urandom % 5) == 0) ? 4'hF : 4'($urandom),
            ($urandom % 100) < 40, ($urandom % 10) == 0, 0, ($urandom % 10) == 0);
      idle(3);
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule